// File: doc/BRIEF.md
# Latched Serial-In Sink Driver Register

This block accepts a serial bit stream on a shift strobe and moves it through a chain of flip-flops. It copies the whole chain into a holding register on a separate latch strobe. The held bits drive one "sink on" flag per channel. A flag at 1 means that channel's low-side switch conducts. An active-low enable gates all flags off at once, so the same pin can be toggled for global PWM dimming without disturbing the held pattern. The last bit of the chain is brought out as a cascade output, which lets several instances be daisy-chained behind one serial source.

The strobes and data are plain inputs sampled on the system clock `clk`. A strobe counts only on a low-to-high change seen between two consecutive clock edges. An active-low clear resets the chain and the holding register at once, without waiting for a clock, so a clear at power-up leaves every channel off.

There is no state machine: each strobe's edge detector is a single delay flop. The only named mode is the output gate, which is either gated (all flags forced off) or following (flags equal the held bits).

Top module: `sipo_sink_driver`

## Requirements
- R1: While `rst_n` is low, every `sink_on` bit and `ser_out` read 0.
- R2: At the first `clk` rising edge where `shift_clk` is sampled 1 after being sampled 0 at the edge before, chain bit i+1 takes bit i and bit 0 takes `ser_in`. `ser_out` is chain bit WIDTH-1. After eight shifts and a latch, `sink_on[0]` equals the last bit shifted in and `sink_on[7]` equals the first.
- R3: Without a rising `shift_clk`, the chain holds its contents whatever `ser_in` does.
- R4: A rising `latch_clk` copies the whole chain into the holding register. Shifting alone leaves `sink_on` unchanged.
- R5: When `shift_clk` and `latch_clk` rise in the same clock cycle, the holding register receives the chain as it was before that shift.
- R6: A low `clr_n` zeroes the chain and the holding register immediately, without a clock edge, and shift and latch strobes have no effect while it stays low.
- R7: With `oe_n` high, every `sink_on` bit is 0 whatever is held, and the held pattern is kept.
- R8: With `oe_n` low, `sink_on` equals the holding register in the same cycle, with no clock delay.
- R9: When one instance's `ser_out` feeds a second instance's `ser_in` and both share strobes, a 16-bit word shifted in MSB first and latched shows its upper byte on the second instance and its lower byte on the first.
- R10: Serial data set up and held at least 20 ns around each shift strobe rise, with every strobe level lasting at least 40 ns, is captured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which strobes are sampled |
| rst_n | input | 1 | Active-low asynchronous reset of the whole block |
| shift_clk | input | 1 | Shift strobe; a rise advances the chain |
| latch_clk | input | 1 | Latch strobe; a rise copies chain to holding register |
| ser_in | input | 1 | Serial data entering chain bit 0 |
| clr_n | input | 1 | Active-low asynchronous clear of chain and holding register |
| oe_n | input | 1 | Active-low output enable / dimming gate |
| sink_on | output | WIDTH | Per-channel sink-on flags (1 = conducting) |
| ser_out | output | 1 | Last chain bit, for cascading |

## Verification
The bench builds the block at its default width of eight channels, which makes every one of the 256 channel patterns reachable in a full sweep. Each pattern is checked through shifting, latching, gating and re-enabling. A second default-width instance chained behind the first brings the cascade path and 16-bit words within reach. The bench also places both strobes in a single cycle, and asserts a clear between clock edges. It measures its own setup, hold and pulse widths against the 20 ns and 40 ns limits.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;
    localparam int unsigned DEF_WIDTH = 8;

    typedef enum logic {
        OUT_GATED  = 1'b0,
        OUT_FOLLOW = 1'b1
    } out_mode_e;
endpackage

// File: rtl/sipo_edge.sv
module sipo_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sipo_chain.sv
module sipo_chain #(
    parameter int unsigned WIDTH = sipo_drv_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             step,
    input  logic             din,
    output logic [WIDTH-1:0] chain
);
    generate
        if (WIDTH == 1) begin : g_single
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)    chain <= '0;
                else if (step) chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)    chain <= '0;
                else if (step) chain <= {chain[WIDTH-2:0], din};
            end

            // R2
            shift_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
                step |=> chain[WIDTH-1:1] == $past(chain[WIDTH-2:0]));
        end
    endgenerate

    // R2
    entry_bit_chk: assert property (@(posedge clk) disable iff (!clr_n)
        step |=> chain[0] == $past(din));

    // R3
    chain_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !step |=> $stable(chain));

    // R6
    chain_clear_chk: assert property (@(posedge clk)
        !clr_n |-> chain == '0);
endmodule

// File: rtl/sipo_hold.sv
module sipo_hold
    import sipo_drv_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load,
    input  logic [WIDTH-1:0] chain,
    input  logic             oe_n,
    output logic [WIDTH-1:0] sink_on
);
    logic [WIDTH-1:0] held;
    out_mode_e        mode;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)    held <= '0;
        else if (load) held <= chain;
    end

    assign mode = oe_n ? OUT_GATED : OUT_FOLLOW;

    always_comb begin
        unique case (mode)
            OUT_GATED:  sink_on = '0;
            OUT_FOLLOW: sink_on = held;
        endcase
    end

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        load |=> held == $past(chain));

    // R4
    held_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load |=> $stable(held));

    // R6
    held_clear_chk: assert property (@(posedge clk)
        !clr_n |-> held == '0);
endmodule

// File: rtl/sipo_sink_driver.sv
module sipo_sink_driver #(
    parameter int unsigned WIDTH = sipo_drv_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_clk,
    input  logic             latch_clk,
    input  logic             ser_in,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] sink_on,
    output logic             ser_out
);
    localparam int unsigned LAST = WIDTH - 1;

    logic             clr_all_n;
    logic             shift_rise;
    logic             latch_rise;
    logic [WIDTH-1:0] chain;

    assign clr_all_n = rst_n & clr_n;

    sipo_edge u_shift_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (shift_clk),
        .rise  (shift_rise)
    );

    sipo_edge u_latch_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (latch_clk),
        .rise  (latch_rise)
    );

    sipo_chain #(.WIDTH(WIDTH)) u_chain (
        .clk   (clk),
        .clr_n (clr_all_n),
        .step  (shift_rise),
        .din   (ser_in),
        .chain (chain)
    );

    sipo_hold #(.WIDTH(WIDTH)) u_hold (
        .clk     (clk),
        .clr_n   (clr_all_n),
        .load    (latch_rise),
        .chain   (chain),
        .oe_n    (oe_n),
        .sink_on (sink_on)
    );

    assign ser_out = chain[LAST];

    // R7
    gate_off_chk: assert property (@(posedge clk)
        oe_n |-> sink_on == '0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (sink_on == '0 && !ser_out));
endmodule

// File: tb/sipo_sink_driver_test.sv
`timescale 1ns/1ps
module sipo_sink_driver_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic shift_clk = 1'b0, latch_clk = 1'b0, ser_in = 1'b0;
    logic clr_n = 1'b1, oe_n = 1'b0;
    logic [7:0] sink_on, sink_on_next;
    logic ser_out, ser_out_next;
    int checks = 0, errors = 0, tviol = 0;
    bit done = 1'b0;
    realtime t_ser = -1.0e6, t_sr = -1.0e6, t_sf = -1.0e6, t_lr = -1.0e6, t_lf = -1.0e6;

    always #2 clk = ~clk;

    sipo_sink_driver #(.WIDTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_clk(latch_clk),
        .ser_in(ser_in), .clr_n(clr_n), .oe_n(oe_n), .sink_on(sink_on), .ser_out(ser_out)
    );

    sipo_sink_driver #(.WIDTH(8)) uut_next (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_clk(latch_clk),
        .ser_in(ser_out), .clr_n(clr_n), .oe_n(oe_n), .sink_on(sink_on_next), .ser_out(ser_out_next)
    );

    // R10 stimulus timing monitor
    always @(ser_in) begin
        if ($realtime - t_sr < 20.0) tviol++;
        t_ser = $realtime;
    end
    always @(posedge shift_clk) begin
        if ($realtime - t_ser < 20.0) tviol++;
        if ($realtime - t_sf < 40.0) tviol++;
        t_sr = $realtime;
    end
    always @(negedge shift_clk) begin
        if ($realtime - t_sr < 40.0) tviol++;
        t_sf = $realtime;
    end
    always @(posedge latch_clk) begin
        if ($realtime - t_lf < 40.0) tviol++;
        t_lr = $realtime;
    end
    always @(negedge latch_clk) begin
        if ($realtime - t_lr < 40.0) tviol++;
        t_lf = $realtime;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        idle(6);
        shift_clk = 1'b1;
        idle(12);
        shift_clk = 1'b0;
        idle(6);
    endtask

    task automatic pulse_latch();
        latch_clk = 1'b1;
        idle(12);
        latch_clk = 1'b0;
        idle(12);
    endtask

    task automatic load_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) shift_bit(v[i]);
    endtask

    initial begin
        logic [7:0] prev;
        logic [15:0] words [3];
        words[0] = 16'hA55A; words[1] = 16'h0FF0; words[2] = 16'h8001;

        idle(3);
        #1;
        chk("R1 sink_on", {8'h0, sink_on}, 16'h0);
        chk("R1 ser_out", {15'h0, ser_out}, 16'h0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R2 R4 R7 R8: full pattern sweep
        prev = 8'h00;
        for (int p = 0; p < 256; p++) begin
            load_byte(p[7:0]);
            #1;
            chk("R2 ser_out", {15'h0, ser_out}, {15'h0, p[7]});
            chk("R4 before latch", {8'h0, sink_on}, {8'h0, prev});
            pulse_latch();
            #1;
            chk("R2 latched", {8'h0, sink_on}, {8'h0, p[7:0]});
            @(negedge clk) oe_n = 1'b1;
            #1;
            chk("R7 gated", {8'h0, sink_on}, 16'h0);
            @(negedge clk) oe_n = 1'b0;
            #1;
            chk("R8 follow", {8'h0, sink_on}, {8'h0, p[7:0]});
            prev = p[7:0];
        end

        // R3: no shift edge, data toggling
        load_byte(8'h5A);
        pulse_latch();
        ser_in = 1'b1;
        idle(30);
        ser_in = 1'b0;
        idle(30);
        pulse_latch();
        #1;
        chk("R3 hold", {8'h0, sink_on}, 16'h005A);

        // R5: simultaneous strobes
        ser_in = 1'b1;
        idle(6);
        shift_clk = 1'b1;
        latch_clk = 1'b1;
        idle(12);
        shift_clk = 1'b0;
        latch_clk = 1'b0;
        idle(12);
        #1;
        chk("R5 old chain", {8'h0, sink_on}, 16'h005A);
        pulse_latch();
        #1;
        chk("R5 new chain", {8'h0, sink_on}, 16'h00B5);

        // R6: asynchronous clear between edges
        @(negedge clk);
        #1 clr_n = 1'b0;
        #0.5;
        chk("R6 async sink", {8'h0, sink_on}, 16'h0);
        chk("R6 async ser_out", {15'h0, ser_out}, 16'h0);
        shift_bit(1'b1);
        pulse_latch();
        #1;
        chk("R6 held low", {8'h0, sink_on}, 16'h0);
        @(negedge clk) clr_n = 1'b1;
        idle(2);
        pulse_latch();
        #1;
        chk("R6 chain cleared", {8'h0, sink_on}, 16'h0);

        // R7: gated while new pattern latched, kept
        load_byte(8'hC3);
        pulse_latch();
        oe_n = 1'b1;
        load_byte(8'h3C);
        pulse_latch();
        #1;
        chk("R7 gated load", {8'h0, sink_on}, 16'h0);
        @(negedge clk) oe_n = 1'b0;
        #1;
        chk("R8 reveal", {8'h0, sink_on}, 16'h003C);

        // R9: cascade of two instances
        for (int w = 0; w < 3; w++) begin
            for (int i = 15; i >= 0; i--) shift_bit(words[w][i]);
            pulse_latch();
            #1;
            chk("R9 cascade", {sink_on_next, sink_on}, words[w]);
        end

        // R10
        chk("R10 timing violations", tviol[15:0], 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule